// File: doc/BRIEF.md
# Ethernet PHY Bring-up and Link-Mode Sequencer

This block drives the command side of an MDIO management master to bring an Ethernet transceiver out of reset into a known configuration and to report the link mode it negotiated. A start pulse runs the bring-up sequence. The sequence first checks the management path: it stores a test word in a scratch ("mirror") register twice, then reads it back. If the word comes back intact, the sequence loads the configuration, advertisement and control registers. The requested speed selects which capabilities are advertised.

A service pulse runs the interrupt-clear reads and then a bounded link poll. The poll reads the chip status register several times with a programmable wait before each read. It then decodes the duplex and speed field into a three-bit link-mode code. A third request writes the transceiver's interrupt-enable register. Every sequence ends with a one-cycle done pulse. Requests are only taken while the block is idle. Register numbers, the test word, the number of polls and the wait length are all parameters.

Top module: `phy_link_seq`

## Requirements
- R1: A bring-up sequence issues, in this order: write TEST_PATTERN to REG_MIRROR, write TEST_PATTERN to REG_MIRROR, read REG_MIRROR, write 0x0000 to REG_CONFIG, write the advertisement word to REG_ADV, write 0x1300 to REG_CTRL.
- R2: If the mirror read-back differs from TEST_PATTERN, the sequence ends after that read. It issues no further command and sets `linkErr` to 1. A bring-up that passes the test clears `linkErr` to 0.
- R3: The advertisement word is 0x0081 when `initFast` is 1 at the start pulse, and 0x0021 when it is 0.
- R4: A service request reads REG_STATUS and then REG_ISTAT, and then runs the link poll of R5.
- R5: The link poll reads REG_CHIP at most POLL_TRIES times. Before each poll read there is a wait of at least POLL_DELAY cycles after the previous response. The poll stops after the first read that has bit 9 set.
- R6: At the end of the poll, `linkMode` is decoded from bits 13:11 of the last read. 3'b111 gives 4 (100 Mb/s full). 3'b101 gives 3 (100 Mb/s half). 3'b110 gives 2 (10 Mb/s full). 3'b100 gives 1 (10 Mb/s half). Any other value gives 0 (not linked). All other status bits are ignored.
- R7: An interrupt-control request writes 0x0002 to REG_IEN when `ienSet` is 1, and 0x0000 when it is 0.
- R8: Every command carries PHY address 0. A command stays valid with stable fields until `cmdReady`. No new command is raised while a response is outstanding.
- R9: `done` is a single-cycle pulse at the end of each sequence. `linkMode` changes only when a poll ends. `linkErr` changes only when a bring-up ends.
- R10: Requests that arrive while a sequence runs are ignored. When several requests arrive together in idle, bring-up wins over service, and service wins over interrupt control.
- R11: After reset, `cmdValid`, `done`, `linkErr` and `linkMode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | 1 | Start a bring-up sequence |
| initFast | input | 1 | Requested speed for bring-up: 1 = 100 Mb/s half, 0 = 10 Mb/s half |
| svcReq | input | 1 | Start interrupt service plus link poll |
| ienReq | input | 1 | Start an interrupt-enable write |
| ienSet | input | 1 | Value for the interrupt-enable write |
| cmdValid | output | 1 | Command request to the MDIO master |
| cmdReady | input | 1 | MDIO master accepts the command |
| cmdWrite | output | 1 | 1 = write, 0 = read |
| cmdPhy | output | 5 | PHY address |
| cmdReg | output | 5 | Register number |
| cmdData | output | 16 | Write data (0 for reads) |
| rspValid | input | 1 | MDIO master finished the accepted command |
| rspData | input | 16 | Read data returned with `rspValid` |
| done | output | 1 | Sequence-finished pulse |
| linkMode | output | 3 | Decoded link mode |
| linkErr | output | 1 | Management-path test failed |

## Verification
The bound checker watches the command handshake on every cycle. It checks that an unaccepted command holds its fields, that there is never a second command while one is in flight, that the PHY address is fixed, that `done` lasts one cycle, and that the wait before each poll read is long enough. It also checks that `linkMode` only holds legal codes and only moves when `done` is pulsed. The order of register accesses, the data written, the decode of every status field, the early stop at each poll position, the priority among requests and the dropping of requests made while busy are all shown only by the bench scenarios. The bench compares a log of transactions and the final results against values it computes.

// File: rtl/phy_link_seq_pkg.sv
package phy_link_seq_pkg;

  typedef enum logic [3:0] {
    STEP_MIR_W1,
    STEP_MIR_W2,
    STEP_MIR_RD,
    STEP_CFG_WR,
    STEP_ADV_WR,
    STEP_CTL_WR,
    STEP_STS_RD,
    STEP_IST_RD,
    STEP_POLL_RD,
    STEP_IEN_WR
  } step_t;

  typedef struct packed {
    logic latchReq;
    logic clrPoll;
    logic incPoll;
    logic startDelay;
    logic setErr;
    logic clrErr;
    logic setMode;
    logic pulseDone;
  } ctlStb_t;

  localparam logic [2:0] MODE_NONE  = 3'd0;
  localparam logic [2:0] MODE_10H   = 3'd1;
  localparam logic [2:0] MODE_10F   = 3'd2;
  localparam logic [2:0] MODE_100H  = 3'd3;
  localparam logic [2:0] MODE_100F  = 3'd4;

  function automatic logic [2:0] decodeMode(input logic [2:0] field);
    case (field)
      3'b111:  return MODE_100F;
      3'b101:  return MODE_100H;
      3'b110:  return MODE_10F;
      3'b100:  return MODE_10H;
      default: return MODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/phy_link_seq_ctrl.sv
module phy_link_seq_ctrl
  import phy_link_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    initReq,
  input  logic    svcReq,
  input  logic    ienReq,
  input  logic    cmdReady,
  input  logic    rspValid,
  input  logic    mirrorOk,
  input  logic    linkUp,
  input  logic    pollLast,
  input  logic    delayDone,
  output logic    cmdValid,
  output step_t   step,
  output ctlStb_t stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DELAY} state_t;

  state_t state, stateNext;
  step_t  stepNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= STEP_MIR_W1;
    end else begin
      state <= stateNext;
      step  <= stepNext;
    end
  end

  always_comb begin
    stateNext = state;
    stepNext  = step;
    stb       = '0;
    cmdValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (initReq) begin
          stb.latchReq = 1'b1;
          stepNext     = STEP_MIR_W1;
          stateNext    = ST_ISSUE;
        end else if (svcReq) begin
          stepNext  = STEP_STS_RD;
          stateNext = ST_ISSUE;
        end else if (ienReq) begin
          stb.latchReq = 1'b1;
          stepNext     = STEP_IEN_WR;
          stateNext    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cmdValid = 1'b1;
        if (cmdReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (rspValid) begin
          stateNext = ST_ISSUE;
          case (step)
            STEP_MIR_W1: stepNext = STEP_MIR_W2;
            STEP_MIR_W2: stepNext = STEP_MIR_RD;
            STEP_MIR_RD: begin
              if (mirrorOk) begin
                stepNext = STEP_CFG_WR;
              end else begin
                stb.setErr    = 1'b1;
                stb.pulseDone = 1'b1;
                stateNext     = ST_IDLE;
              end
            end
            STEP_CFG_WR: stepNext = STEP_ADV_WR;
            STEP_ADV_WR: stepNext = STEP_CTL_WR;
            STEP_CTL_WR: begin
              stb.clrErr    = 1'b1;
              stb.pulseDone = 1'b1;
              stateNext     = ST_IDLE;
            end
            STEP_STS_RD: stepNext = STEP_IST_RD;
            STEP_IST_RD: begin
              stb.clrPoll    = 1'b1;
              stb.startDelay = 1'b1;
              stepNext       = STEP_POLL_RD;
              stateNext      = ST_DELAY;
            end
            STEP_POLL_RD: begin
              stb.incPoll = 1'b1;
              if (linkUp || pollLast) begin
                stb.setMode   = 1'b1;
                stb.pulseDone = 1'b1;
                stateNext     = ST_IDLE;
              end else begin
                stb.startDelay = 1'b1;
                stateNext      = ST_DELAY;
              end
            end
            default: begin
              stb.pulseDone = 1'b1;
              stateNext     = ST_IDLE;
            end
          endcase
        end
      end
      ST_DELAY: begin
        if (delayDone) stateNext = ST_ISSUE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/phy_link_seq_dp.sv
module phy_link_seq_dp
  import phy_link_seq_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR     = 5'd0,
  parameter logic [4:0]  REG_CTRL     = 5'd0,
  parameter logic [4:0]  REG_STATUS   = 5'd1,
  parameter logic [4:0]  REG_ADV      = 5'd4,
  parameter logic [4:0]  REG_MIRROR   = 5'd16,
  parameter logic [4:0]  REG_IEN      = 5'd17,
  parameter logic [4:0]  REG_ISTAT    = 5'd18,
  parameter logic [4:0]  REG_CONFIG   = 5'd19,
  parameter logic [4:0]  REG_CHIP     = 5'd20,
  parameter logic [15:0] TEST_PATTERN = 16'h5AC3,
  parameter int          POLL_TRIES   = 5,
  parameter int          POLL_DELAY   = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStb_t     stb,
  input  step_t       step,
  input  logic        initFast,
  input  logic        ienSet,
  input  logic [15:0] rspData,
  output logic        cmdWrite,
  output logic [4:0]  cmdPhy,
  output logic [4:0]  cmdReg,
  output logic [15:0] cmdData,
  output logic        mirrorOk,
  output logic        linkUp,
  output logic        pollLast,
  output logic        delayDone,
  output logic        done,
  output logic [2:0]  linkMode,
  output logic        linkErr
);

  localparam int PW = $clog2(POLL_TRIES + 1);
  localparam int DW = $clog2(POLL_DELAY + 1);
  localparam logic [PW-1:0] POLL_MAX  = PW'(POLL_TRIES - 1);
  localparam logic [DW-1:0] DELAY_LD  = DW'(POLL_DELAY);
  localparam logic [15:0]   ADV_FAST  = 16'h0081;
  localparam logic [15:0]   ADV_SLOW  = 16'h0021;
  localparam logic [15:0]   CTL_WORD  = 16'h1300;
  localparam logic [15:0]   IEN_WORD  = 16'h0002;
  localparam int            UP_BIT    = 9;

  logic          fastLat, ienLat;
  logic [PW-1:0] pollCnt;
  logic [DW-1:0] delayCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastLat  <= 1'b0;
      ienLat   <= 1'b0;
      pollCnt  <= '0;
      delayCnt <= '0;
      done     <= 1'b0;
      linkMode <= MODE_NONE;
      linkErr  <= 1'b0;
    end else begin
      done <= stb.pulseDone;
      if (stb.latchReq) begin
        fastLat <= initFast;
        ienLat  <= ienSet;
      end
      if (stb.clrPoll)      pollCnt <= '0;
      else if (stb.incPoll) pollCnt <= pollCnt + 1'b1;
      if (stb.startDelay)   delayCnt <= DELAY_LD;
      else if (!delayDone)  delayCnt <= delayCnt - 1'b1;
      if (stb.setErr)       linkErr <= 1'b1;
      else if (stb.clrErr)  linkErr <= 1'b0;
      if (stb.setMode)      linkMode <= decodeMode(rspData[13:11]);
    end
  end

  assign delayDone = (delayCnt == '0);
  assign pollLast  = (pollCnt >= POLL_MAX);
  assign linkUp    = rspData[UP_BIT];
  assign mirrorOk  = (rspData == TEST_PATTERN);
  assign cmdPhy    = PHY_ADDR;

  always_comb begin
    cmdWrite = 1'b0;
    cmdReg   = REG_CHIP;
    cmdData  = 16'h0000;
    case (step)
      STEP_MIR_W1, STEP_MIR_W2: begin
        cmdWrite = 1'b1; cmdReg = REG_MIRROR; cmdData = TEST_PATTERN;
      end
      STEP_MIR_RD:  cmdReg = REG_MIRROR;
      STEP_CFG_WR: begin
        cmdWrite = 1'b1; cmdReg = REG_CONFIG;
      end
      STEP_ADV_WR: begin
        cmdWrite = 1'b1; cmdReg = REG_ADV; cmdData = fastLat ? ADV_FAST : ADV_SLOW;
      end
      STEP_CTL_WR: begin
        cmdWrite = 1'b1; cmdReg = REG_CTRL; cmdData = CTL_WORD;
      end
      STEP_STS_RD:  cmdReg = REG_STATUS;
      STEP_IST_RD:  cmdReg = REG_ISTAT;
      STEP_IEN_WR: begin
        cmdWrite = 1'b1; cmdReg = REG_IEN; cmdData = ienLat ? IEN_WORD : 16'h0000;
      end
      default:      cmdReg = REG_CHIP;
    endcase
  end

endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_seq_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR     = 5'd0,
  parameter logic [4:0]  REG_CTRL     = 5'd0,
  parameter logic [4:0]  REG_STATUS   = 5'd1,
  parameter logic [4:0]  REG_ADV      = 5'd4,
  parameter logic [4:0]  REG_MIRROR   = 5'd16,
  parameter logic [4:0]  REG_IEN      = 5'd17,
  parameter logic [4:0]  REG_ISTAT    = 5'd18,
  parameter logic [4:0]  REG_CONFIG   = 5'd19,
  parameter logic [4:0]  REG_CHIP     = 5'd20,
  parameter logic [15:0] TEST_PATTERN = 16'h5AC3,
  parameter int          POLL_TRIES   = 5,
  parameter int          POLL_DELAY   = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  logic        initFast,
  input  logic        svcReq,
  input  logic        ienReq,
  input  logic        ienSet,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic        cmdWrite,
  output logic [4:0]  cmdPhy,
  output logic [4:0]  cmdReg,
  output logic [15:0] cmdData,
  input  logic        rspValid,
  input  logic [15:0] rspData,
  output logic        done,
  output logic [2:0]  linkMode,
  output logic        linkErr
);

  ctlStb_t stb;
  step_t   step;
  logic    mirrorOk, linkUp, pollLast, delayDone;

  phy_link_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .initReq(initReq), .svcReq(svcReq), .ienReq(ienReq),
    .cmdReady(cmdReady), .rspValid(rspValid),
    .mirrorOk(mirrorOk), .linkUp(linkUp), .pollLast(pollLast), .delayDone(delayDone),
    .cmdValid(cmdValid), .step(step), .stb(stb)
  );

  phy_link_seq_dp #(
    .PHY_ADDR(PHY_ADDR), .REG_CTRL(REG_CTRL), .REG_STATUS(REG_STATUS), .REG_ADV(REG_ADV),
    .REG_MIRROR(REG_MIRROR), .REG_IEN(REG_IEN), .REG_ISTAT(REG_ISTAT),
    .REG_CONFIG(REG_CONFIG), .REG_CHIP(REG_CHIP), .TEST_PATTERN(TEST_PATTERN),
    .POLL_TRIES(POLL_TRIES), .POLL_DELAY(POLL_DELAY)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .step(step),
    .initFast(initFast), .ienSet(ienSet), .rspData(rspData),
    .cmdWrite(cmdWrite), .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdData(cmdData),
    .mirrorOk(mirrorOk), .linkUp(linkUp), .pollLast(pollLast), .delayDone(delayDone),
    .done(done), .linkMode(linkMode), .linkErr(linkErr)
  );

endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk #(
  parameter logic [4:0] REG_CHIP   = 5'd20,
  parameter int          POLL_DELAY = 1000
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic        cmdWrite,
  input logic [4:0]  cmdPhy,
  input logic [4:0]  cmdReg,
  input logic [15:0] cmdData,
  input logic        rspValid,
  input logic        done,
  input logic [2:0]  linkMode
);

  localparam int GW = $clog2(POLL_DELAY + 2) + 1;
  localparam logic [GW-1:0] GAP_CAP = GW'(POLL_DELAY + 1);

  logic          inFlight;
  logic [GW-1:0] sinceRsp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      sinceRsp <= '0;
    end else begin
      if (cmdValid && cmdReady) inFlight <= 1'b1;
      else if (rspValid)        inFlight <= 1'b0;
      if (rspValid)                 sinceRsp <= '0;
      else if (sinceRsp < GAP_CAP)  sinceRsp <= sinceRsp + 1'b1;
    end
  end

  // R8
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdWrite) && $stable(cmdReg) && $stable(cmdData)));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !cmdValid);

  // R8
  phy_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdPhy == 5'd0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkMode <= 3'd4);

  // R9
  mode_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(linkMode) |-> done);

  // R5
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdWrite && cmdReg == REG_CHIP) |-> (sinceRsp >= GW'(POLL_DELAY)));

endmodule

bind phy_link_seq phy_link_seq_chk #(.REG_CHIP(REG_CHIP), .POLL_DELAY(POLL_DELAY)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWrite(cmdWrite),
  .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdData(cmdData), .rspValid(rspValid),
  .done(done), .linkMode(linkMode)
);

// File: tb/phy_link_seq_tb_top.sv
`timescale 1ns/1ps
module phy_link_seq_tb_top;

  localparam int          TRIES  = 5;
  localparam int          DLY    = 6;
  localparam logic [4:0]  R_CTRL = 5'd0,  R_STS = 5'd1,  R_ADV = 5'd4,  R_MIR = 5'd16;
  localparam logic [4:0]  R_IEN  = 5'd17, R_IST = 5'd18, R_CFG = 5'd19, R_CHIP = 5'd20;
  localparam logic [15:0] PAT    = 16'h5AC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 0, initFast = 0, svcReq = 0, ienReq = 0, ienSet = 0;
  logic cmdValid, cmdReady, cmdWrite;
  logic [4:0] cmdPhy, cmdReg;
  logic [15:0] cmdData;
  logic rspValid = 1'b0;
  logic [15:0] rspData = 16'h0;
  logic done, linkErr;
  logic [2:0] linkMode;

  always #10 clk = ~clk;

  phy_link_seq #(.POLL_TRIES(TRIES), .POLL_DELAY(DLY), .TEST_PATTERN(PAT)) dut_i (
    .clk(clk), .rstN(rstN), .initReq(initReq), .initFast(initFast), .svcReq(svcReq),
    .ienReq(ienReq), .ienSet(ienSet), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData), .done(done), .linkMode(linkMode), .linkErr(linkErr)
  );

  // MDIO master model with transaction log
  logic        busyM = 1'b0;
  int          latM = 0;
  logic [15:0] regs [32];
  logic        logW [64];
  logic [4:0]  logR [64];
  logic [15:0] logD [64];
  int          logCnt = 0, pollN = 0, sinceRsp = 0, minGap = 1000, doneCnt = 0;
  logic        clrLog = 1'b0, mirBad = 1'b0;
  int          statK = 0;
  logic [2:0]  statField = 3'd0;
  logic [15:0] nextData = 16'h0;

  assign cmdReady = cmdValid && !busyM;

  always @(posedge clk) begin
    rspValid <= 1'b0;
    if (done) doneCnt <= doneCnt + 1;
    if (rspValid) sinceRsp <= 0; else sinceRsp <= sinceRsp + 1;
    if (clrLog) begin
      logCnt <= 0; pollN <= 0; minGap <= 1000; doneCnt <= 0;
    end else if (cmdValid && cmdReady) begin
      if (logCnt < 64) begin
        logW[logCnt] <= cmdWrite; logR[logCnt] <= cmdReg; logD[logCnt] <= cmdData;
      end
      logCnt <= logCnt + 1;
      if (cmdWrite) begin
        regs[cmdReg] <= cmdData; nextData <= 16'h0;
      end else if (cmdReg == R_CHIP) begin
        pollN <= pollN + 1;
        if (sinceRsp < minGap) minGap <= sinceRsp;
        nextData <= 16'h8005 | (16'(statField) << 11) |
                    (((statK != 0) && (pollN + 1 >= statK)) ? 16'h0200 : 16'h0);
      end else if (cmdReg == R_MIR) begin
        nextData <= regs[R_MIR] ^ (mirBad ? 16'h0100 : 16'h0);
      end else begin
        nextData <= 16'h1234;
      end
      busyM <= 1'b1; latM <= 2;
    end
    if (busyM && !(cmdValid && cmdReady)) begin
      if (latM == 0) begin
        busyM <= 1'b0; rspValid <= 1'b1; rspData <= nextData;
      end else latM <= latM - 1;
    end
  end

  int errs = 0, checks = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEntry(input int i, input logic w, input logic [4:0] r,
                          input logic [15:0] d, input string tag);
    chk(logW[i] == w && logR[i] == r && (!w || logD[i] == d), tag,
        {logW[i], 3'b0, logR[i], logD[i]}, {w, 3'b0, r, d});
  endtask

  task automatic clearLog();
    @(negedge clk) clrLog = 1'b1;
    @(negedge clk) clrLog = 1'b0;
  endtask

  task automatic waitDone();
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (done) return;
    end
    chk(1'b0, "R9 done timeout", 0, 1);
  endtask

  function automatic logic [2:0] expMode(input logic [2:0] f);
    if (f == 3'b111) return 3'd4;
    if (f == 3'b101) return 3'd3;
    if (f == 3'b110) return 3'd2;
    if (f == 3'b100) return 3'd1;
    return 3'd0;
  endfunction

  task automatic runInit(input logic fast, input logic bad);
    clearLog();
    mirBad = bad;
    @(negedge clk) begin initReq = 1; initFast = fast; end
    @(negedge clk) initReq = 0;
    waitDone();
    if (bad) begin
      @(negedge clk);
      chk(logCnt == 3, "R2 stop after bad readback", logCnt, 3);
      chk(linkErr == 1'b1, "R2 linkErr set", linkErr, 1);
    end else begin
      chk(logCnt == 6, "R1 access count", logCnt, 6);
      chkEntry(0, 1, R_MIR, PAT, "R1 mirror write 1");
      chkEntry(1, 1, R_MIR, PAT, "R1 mirror write 2");
      chkEntry(2, 0, R_MIR, 0, "R1 mirror read");
      chkEntry(3, 1, R_CFG, 16'h0000, "R1 config write");
      chkEntry(4, 1, R_ADV, fast ? 16'h0081 : 16'h0021, "R3 advertisement");
      chkEntry(5, 1, R_CTRL, 16'h1300, "R1 control write");
      chk(linkErr == 1'b0, "R2 linkErr cleared", linkErr, 0);
    end
  endtask

  task automatic runSvc(input int k, input logic [2:0] f);
    int nExp;
    clearLog();
    statK = k; statField = f;
    nExp = (k == 0 || k > TRIES) ? TRIES : k;
    @(negedge clk) svcReq = 1;
    @(negedge clk) svcReq = 0;
    waitDone();
    chk(logCnt == 2 + nExp, "R5 poll count", logCnt, 2 + nExp);
    chkEntry(0, 0, R_STS, 0, "R4 status read first");
    chkEntry(1, 0, R_IST, 0, "R4 istat read second");
    chk(logR[2 + nExp - 1] == R_CHIP, "R5 last read is chip status", logR[2 + nExp - 1], R_CHIP);
    chk(minGap >= DLY, "R5 poll wait", minGap, DLY);
    chk(linkMode == expMode(f), "R6 link mode", linkMode, expMode(f));
  endtask

  logic [2:0] keepMode;

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(cmdValid == 0 && done == 0 && linkErr == 0 && linkMode == 0, "R11 reset state",
        {cmdValid, done, linkErr, linkMode}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runInit(1'b0, 1'b1);
    runInit(1'b1, 1'b0);
    runInit(1'b0, 1'b0);
    runInit(1'b0, 1'b1);
    runInit(1'b1, 1'b0);
    mirBad = 1'b0;

    for (int k = 0; k <= TRIES; k++)
      for (int f = 0; f < 8; f++)
        runSvc(k, 3'(f));

    // R7 interrupt enable writes, R9 linkMode held
    keepMode = linkMode;
    for (int e = 0; e < 2; e++) begin
      clearLog();
      @(negedge clk) begin ienReq = 1; ienSet = e[0]; end
      @(negedge clk) ienReq = 0;
      waitDone();
      @(negedge clk);
      chk(logCnt == 1, "R7 single access", logCnt, 1);
      chkEntry(0, 1, R_IEN, e[0] ? 16'h0002 : 16'h0000, "R7 enable word");
      chk(linkMode == keepMode, "R9 linkMode held over ien", linkMode, keepMode);
    end

    // R10 priority when simultaneous
    clearLog();
    @(negedge clk) begin initReq = 1; svcReq = 1; ienReq = 1; initFast = 0; end
    @(negedge clk) begin initReq = 0; svcReq = 0; ienReq = 0; end
    waitDone();
    chkEntry(0, 1, R_MIR, PAT, "R10 init wins");
    clearLog();
    @(negedge clk) begin svcReq = 1; ienReq = 1; statK = 1; statField = 3'b101; end
    @(negedge clk) begin svcReq = 0; ienReq = 0; end
    waitDone();
    chkEntry(0, 0, R_STS, 0, "R10 service beats ien");

    // R10 requests during a running sequence are dropped
    clearLog();
    statK = 0; statField = 3'b110;
    @(negedge clk) svcReq = 1;
    @(negedge clk) svcReq = 0;
    repeat (15) @(negedge clk);
    @(negedge clk) begin initReq = 1; ienReq = 1; ienSet = 1; end
    @(negedge clk) begin initReq = 0; ienReq = 0; end
    waitDone();
    repeat (40) @(negedge clk);
    chk(logCnt == 2 + TRIES, "R10 busy requests ignored", logCnt, 2 + TRIES);
    chk(doneCnt == 1, "R9 one done per sequence", doneCnt, 1);
    chk(linkErr == 1'b0, "R9 linkErr untouched by poll", linkErr, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule